// File: doc/BRIEF.md
# Robbed-Bit Signaling Extractor with Integration and Freeze

This block pulls robbed-bit signaling out of a received T1 channel stream and presents it per channel on the system side. Each received byte arrives on a valid/ready stream together with its channel index (0 to 23) and its frame number inside the multiframe (1 to 24). In the signaling frames the least significant bit of the byte is captured into a per-channel capture register. On each rising edge of the system multiframe sync, every channel's captured value passes through a debounce filter. It then updates that channel's output register unless updates are frozen.

The system side selects a channel with `sys_chan`. The block returns that channel's four signaling bits on `sig_abcd` one clock later. A strobe marks the least significant bit time of each channel, so external logic can put the signaling back into outgoing data. The block itself never merges signaling into PCM data. Freezes come from a slip pulse, which lasts a number of multiframes set by the integration select, or from an active-low hold level. A status flag reports the freeze. An alarm level, like a recent slip, shortens the debounce to two multiframes.

The receive stream never applies back-pressure: `rx_ready` is held high after reset. Every cycle with `rx_valid` high is one accepted byte. Bytes whose channel index is 24 or above are accepted and dropped.

Top module: `rbs_extractor`

## Requirements
- R1: Only bit 0 of an accepted byte is captured, and only in frames 6, 12, 18 and 24. Bytes in other frames, and bits 7..1, leave every output unchanged.
- R2: With `esf_mode`=0, A (`sig_abcd[3]`) is taken in frame 6 and B (`sig_abcd[2]`) in frame 12. Bytes in frames 18 and 24 are ignored.
- R3: With `esf_mode`=1, A, B, C (`sig_abcd[1]`) and D (`sig_abcd[0]`) are taken in frames 6, 12, 18 and 24 respectively.
- R4: With `esf_mode`=0, each output update loads C and D with the A and B values the channel presented before that update.
- R5: A channel's output changes only on the first clock with `sys_msync` high after a clock with it low. `sig_abcd` shows the output of channel `sys_chan` one clock after `sys_chan` is applied.
- R6: While `hold_n` is low, no output update takes place.
- R7: `sig_frozen` rises one clock after `slip` is high or `hold_n` is low. It falls at the next multiframe edge on which updates are allowed.
- R8: `integ_sel` sets how many consecutive multiframes with an equal sampled value are needed before an update: 00 needs 1, 01 needs 2, 10 needs 3 and 11 needs 4. In superframe mode only A and B are compared.
- R9: While `alarm` is high, the needed count is at most 2.
- R10: A `slip` pulse blocks the next 1, 1, 2 or 3 multiframe edges for `integ_sel` 00, 01, 10 or 11. Until the first allowed update after a slip, the needed count is at most 2.
- R11: `lsb_strobe` is high one clock after `sys_bitpos` equals 7, and low one clock after any other value.
- R12: After reset, all outputs read 0000, `sig_frozen` and `lsb_strobe` are low, and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Always high after reset; no back-pressure |
| rx_chan | input | 5 | Channel index of the byte |
| rx_frame | input | 5 | Frame number in the multiframe, 1..24 |
| rx_data | input | 8 | Received channel byte |
| esf_mode | input | 1 | 0 = superframe, 1 = extended superframe |
| integ_sel | input | 2 | Debounce depth and slip freeze length |
| slip | input | 1 | Slip pulse, one clock |
| alarm | input | 1 | Alarm level, caps debounce depth |
| hold_n | input | 1 | Active-low hold, blocks updates |
| sys_msync | input | 1 | System multiframe sync |
| sys_chan | input | 5 | Channel presented on the system side |
| sys_bitpos | input | 3 | Bit position inside the presented channel |
| sig_abcd | output | 4 | Signaling A,B,C,D at bits 3,2,1,0 |
| lsb_strobe | output | 1 | Marks the channel LSB bit time |
| sig_frozen | output | 1 | Freeze status |

## Verification
An accepted byte reaches the capture register at the clock edge that takes it. The output array changes at the edge where the rising `sys_msync` is first seen. `sig_abcd` follows one edge after `sys_chan` or the array changes, and `sig_frozen` and `lsb_strobe` follow one edge after their causes. The bench's driver stamps every expected item with the cycle number when the result is due: the application cycle plus one register stage. It probes only after a full sync pulse has settled. The monitor compares each item at the falling edge of exactly that cycle, so no result is sampled before its register has loaded.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int unsigned SIG_W   = 4;
  localparam int unsigned FRAME_W = 5;

  // frame numbers carrying each signaling bit
  localparam logic [FRAME_W-1:0] FRM_A = 5'd6;
  localparam logic [FRAME_W-1:0] FRM_B = 5'd12;
  localparam logic [FRAME_W-1:0] FRM_C = 5'd18;
  localparam logic [FRAME_W-1:0] FRM_D = 5'd24;

  // bit positions inside a signaling nibble
  localparam int unsigned POS_A = 3;
  localparam int unsigned POS_B = 2;
  localparam int unsigned POS_C = 1;
  localparam int unsigned POS_D = 0;

  typedef logic [SIG_W-1:0] sig_t;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'b00,
    DEPTH_2 = 2'b01,
    DEPTH_3 = 2'b10,
    DEPTH_4 = 2'b11
  } depth_e;

  // multiframes of agreement needed before an update
  function automatic logic [2:0] agree_need(input logic [1:0] sel, input logic capped);
    logic [2:0] n;
    case (depth_e'(sel))
      DEPTH_1: n = 3'd1;
      DEPTH_2: n = 3'd2;
      DEPTH_3: n = 3'd3;
      default: n = 3'd4;
    endcase
    if (capped && n > 3'd2) n = 3'd2;
    return n;
  endfunction

  // multiframe edges blocked after a slip
  function automatic logic [1:0] slip_span(input logic [1:0] sel);
    case (depth_e'(sel))
      DEPTH_1: return 2'd1;
      DEPTH_2: return 2'd1;
      DEPTH_3: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/rbs_capture.sv
module rbs_capture
  import rbs_pkg::*;
#(
  parameter int unsigned NUM_CH = 24,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic [FRAME_W-1:0]      wr_frame,
  input  logic                    wr_bit,
  input  logic                    esf,
  output logic [NUM_CH*SIG_W-1:0] cap_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sig_t cap_q;
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cap_q <= '0;
      end else if (hit) begin
        if (wr_frame == FRM_A)        cap_q[POS_A] <= wr_bit;
        if (wr_frame == FRM_B)        cap_q[POS_B] <= wr_bit;
        if (esf && wr_frame == FRM_C) cap_q[POS_C] <= wr_bit;
        if (esf && wr_frame == FRM_D) cap_q[POS_D] <= wr_bit;
      end
    end

    assign cap_flat[g*SIG_W +: SIG_W] = cap_q;
  end
endmodule

// File: rtl/rbs_freeze_ctl.sv
module rbs_freeze_ctl
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msync,
  input  logic       slip,
  input  logic       alarm,
  input  logic       hold_n,
  input  logic [1:0] sel,
  output logic       evt,
  output logic       load_ok,
  output logic [2:0] need,
  output logic       frozen
);
  logic       msync_q;
  logic [1:0] block_cnt;
  logic       slip_seen;

  assign evt     = msync && !msync_q;
  assign load_ok = hold_n && !slip && (block_cnt == 2'd0);
  assign need    = agree_need(sel, alarm || slip_seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msync_q   <= 1'b0;
      block_cnt <= 2'd0;
      slip_seen <= 1'b0;
      frozen    <= 1'b0;
    end else begin
      msync_q <= msync;

      if (slip)                              block_cnt <= slip_span(sel);
      else if (evt && block_cnt != 2'd0)     block_cnt <= block_cnt - 2'd1;

      if (slip)                              slip_seen <= 1'b1;
      else if (evt && load_ok)               slip_seen <= 1'b0;

      if (slip || !hold_n)                   frozen <= 1'b1;
      else if (evt && load_ok)               frozen <= 1'b0;
    end
  end
endmodule

// File: rtl/rbs_integrator.sv
module rbs_integrator
  import rbs_pkg::*;
#(
  parameter int unsigned NUM_CH = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt,
  input  logic                    load_ok,
  input  logic                    esf,
  input  logic [2:0]              need,
  input  logic [NUM_CH*SIG_W-1:0] cap_flat,
  output logic [NUM_CH*SIG_W-1:0] out_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sig_t       pend_q;
    sig_t       out_q;
    logic [1:0] run_q;
    sig_t       samp;
    logic [2:0] run_nx;

    // superframe compares only A and B
    assign samp   = esf ? cap_flat[g*SIG_W +: SIG_W]
                        : {cap_flat[g*SIG_W+POS_A], cap_flat[g*SIG_W+POS_B], 2'b00};
    assign run_nx = (samp != pend_q) ? 3'd1
                  : (run_q == 2'd3)  ? 3'd4
                  : {1'b0, run_q} + 3'd2;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= '0;
        out_q  <= '0;
        run_q  <= 2'd3;
      end else if (evt) begin
        pend_q <= samp;
        run_q  <= 2'(run_nx - 3'd1);
        if (load_ok && run_nx >= need) begin
          if (esf) out_q <= samp;
          else     out_q <= {samp[POS_A], samp[POS_B], out_q[POS_A], out_q[POS_B]};
        end
      end
    end

    assign out_flat[g*SIG_W +: SIG_W] = out_q;
  end
endmodule

// File: rtl/rbs_extractor.sv
module rbs_extractor
  import rbs_pkg::*;
#(
  parameter int unsigned NUM_CH = 24,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [CH_W-1:0]    rx_chan,
  input  logic [FRAME_W-1:0] rx_frame,
  input  logic [7:0]         rx_data,
  input  logic               esf_mode,
  input  logic [1:0]         integ_sel,
  input  logic               slip,
  input  logic               alarm,
  input  logic               hold_n,
  input  logic               sys_msync,
  input  logic [CH_W-1:0]    sys_chan,
  input  logic [2:0]         sys_bitpos,
  output logic [SIG_W-1:0]   sig_abcd,
  output logic               lsb_strobe,
  output logic               sig_frozen
);
  localparam logic [2:0] LSB_POS = 3'd7;

  logic                    rdy_q;
  logic                    accept;
  logic [NUM_CH*SIG_W-1:0] cap_flat;
  logic [NUM_CH*SIG_W-1:0] out_flat;
  logic                    msync_evt;
  logic                    load_ok;
  logic [2:0]              need;
  logic                    unused_hi;

  assign rx_ready  = rdy_q;
  assign accept    = rx_valid && rdy_q;
  assign unused_hi = ^rx_data[7:1];

  rbs_capture #(.NUM_CH(NUM_CH)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_ch(rx_chan),
    .wr_frame(rx_frame), .wr_bit(rx_data[0]), .esf(esf_mode), .cap_flat(cap_flat)
  );

  rbs_freeze_ctl u_frz (
    .clk(clk), .rst_n(rst_n), .msync(sys_msync), .slip(slip), .alarm(alarm),
    .hold_n(hold_n), .sel(integ_sel), .evt(msync_evt), .load_ok(load_ok),
    .need(need), .frozen(sig_frozen)
  );

  rbs_integrator #(.NUM_CH(NUM_CH)) u_int (
    .clk(clk), .rst_n(rst_n), .evt(msync_evt), .load_ok(load_ok), .esf(esf_mode),
    .need(need), .cap_flat(cap_flat), .out_flat(out_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      sig_abcd   <= '0;
      lsb_strobe <= 1'b0;
    end else begin
      rdy_q      <= 1'b1;
      lsb_strobe <= (sys_bitpos == LSB_POS);
      if (int'(sys_chan) < NUM_CH) sig_abcd <= out_flat[sys_chan*SIG_W +: SIG_W];
      else                         sig_abcd <= '0;
    end
  end
endmodule

// File: rtl/rbs_extractor_chk.sv
module rbs_extractor_chk #(
  parameter int unsigned NUM_CH = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hold_n,
  input logic                slip,
  input logic [2:0]          sys_bitpos,
  input logic                lsb_strobe,
  input logic                sig_frozen,
  input logic                msync_evt,
  input logic [NUM_CH*4-1:0] out_flat
);
  // R5
  outputs_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msync_evt |=> $stable(out_flat));

  // R6
  hold_blocks_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msync_evt && !hold_n) |=> $stable(out_flat));

  // R7
  hold_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> sig_frozen);

  // R7
  flag_clears_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_frozen) |-> $past(msync_evt));

  // R10
  slip_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> sig_frozen);

  // R11
  strobe_follows_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_bitpos == 3'd7) |=> lsb_strobe);
endmodule

bind rbs_extractor rbs_extractor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .slip(slip),
  .sys_bitpos(sys_bitpos), .lsb_strobe(lsb_strobe), .sig_frozen(sig_frozen),
  .msync_evt(msync_evt), .out_flat(out_flat)
);

// File: tb/tb_rbs_extractor.sv
`timescale 1ns/1ps
module tb_rbs_extractor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [4:0] rx_chan = '0;
  logic [4:0] rx_frame = '0;
  logic [7:0] rx_data = '0;
  logic       esf_mode = 1'b0;
  logic [1:0] integ_sel = 2'b00;
  logic       slip = 1'b0;
  logic       alarm = 1'b0;
  logic       hold_n = 1'b1;
  logic       sys_msync = 1'b0;
  logic [4:0] sys_chan = '0;
  logic [2:0] sys_bitpos = '0;
  logic [3:0] sig_abcd;
  logic       lsb_strobe;
  logic       sig_frozen;

  always #2 clk = ~clk;

  rbs_extractor dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_chan(rx_chan), .rx_frame(rx_frame), .rx_data(rx_data),
    .esf_mode(esf_mode), .integ_sel(integ_sel), .slip(slip), .alarm(alarm),
    .hold_n(hold_n), .sys_msync(sys_msync), .sys_chan(sys_chan),
    .sys_bitpos(sys_bitpos), .sig_abcd(sig_abcd), .lsb_strobe(lsb_strobe),
    .sig_frozen(sig_frozen)
  );

  typedef struct {
    int         due;
    logic [3:0] sig;
    logic       frz;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sig_abcd !== it.sig || sig_frozen !== it.frz) begin
        errors++;
        $display("FAIL %s: sig=%b frz=%b expected sig=%b frz=%b",
                 it.tag, sig_abcd, sig_frozen, it.sig, it.frz);
      end
    end
  end

  task automatic probe(input int ch, input logic [3:0] sig, input logic frz, input string tag);
    item_t it;
    sys_chan = 5'(ch);
    it.due = cyc + 1; it.sig = sig; it.frz = frz; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send_byte(input int ch, input int fr, input logic [7:0] d);
    rx_valid = 1'b1; rx_chan = 5'(ch); rx_frame = 5'(fr); rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_mf(input int ch, input logic [3:0] v);
    send_byte(ch, 6,  {7'h2A, v[3]});
    send_byte(ch, 12, {7'h55, v[2]});
    send_byte(ch, 18, {7'h2A, v[1]});
    send_byte(ch, 24, {7'h55, v[0]});
  endtask

  task automatic mf_edge();
    sys_msync = 1'b1;
    @(negedge clk);
    sys_msync = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // R12: reset state
    check_bit(rx_ready, 1'b1, "R12 rx_ready");
    check_bit(lsb_strobe, 1'b0, "R12 strobe");
    probe(0, 4'b0000, 1'b0, "R12 reset outputs");

    // R1 R2: superframe capture, ignored frames and upper bits
    send_byte(3, 5, 8'h01);
    send_byte(3, 6, 8'h01);
    send_byte(3, 7, 8'h00);
    send_byte(3, 12, 8'hFE);
    send_byte(3, 18, 8'h01);
    send_byte(3, 24, 8'h01);
    probe(3, 4'b0000, 1'b0, "R5 no update without sync edge");
    mf_edge();
    probe(3, 4'b1000, 1'b0, "R1 R2 superframe A/B");
    probe(4, 4'b0000, 1'b0, "R1 other channel untouched");

    // R4: C/D carry previous A/B in superframe
    send_byte(3, 6, 8'h00);
    send_byte(3, 12, 8'h01);
    mf_edge();
    probe(3, 4'b0110, 1'b0, "R4 previous A/B on C/D");

    // R11: LSB strobe
    sys_bitpos = 3'd7;
    @(negedge clk);
    check_bit(lsb_strobe, 1'b1, "R11 strobe at bit 7");
    sys_bitpos = 3'd6;
    @(negedge clk);
    check_bit(lsb_strobe, 1'b0, "R11 strobe off");

    // R3: extended superframe
    esf_mode = 1'b1;
    send_mf(23, 4'b1011);
    mf_edge();
    probe(23, 4'b1011, 1'b0, "R3 ESF A/B/C/D");

    // R6 R7: hold
    hold_n = 1'b0;
    send_mf(10, 4'b0101);
    probe(10, 4'b0000, 1'b1, "R7 hold raises flag");
    mf_edge();
    probe(10, 4'b0000, 1'b1, "R6 hold blocks update");
    hold_n = 1'b1;
    probe(10, 4'b0000, 1'b1, "R7 flag held until update");
    mf_edge();
    probe(10, 4'b0101, 1'b0, "R7 update clears flag");

    // R8: depth 2
    integ_sel = 2'b01;
    send_mf(5, 4'b1100);
    mf_edge();
    probe(5, 4'b0000, 1'b0, "R8 depth2 first mf");
    mf_edge();
    probe(5, 4'b1100, 1'b0, "R8 depth2 second mf");

    // R8: depth 4
    integ_sel = 2'b11;
    send_mf(6, 4'b0110);
    mf_edge();
    mf_edge();
    mf_edge();
    probe(6, 4'b0000, 1'b0, "R8 depth4 third mf");
    mf_edge();
    probe(6, 4'b0110, 1'b0, "R8 depth4 fourth mf");

    // R9: alarm caps depth
    alarm = 1'b1;
    send_mf(7, 4'b1001);
    mf_edge();
    probe(7, 4'b0000, 1'b0, "R9 alarm first mf");
    mf_edge();
    probe(7, 4'b1001, 1'b0, "R9 alarm capped at two");
    alarm = 1'b0;

    // R10: slip with depth 3 blocks two edges, then cap 2
    integ_sel = 2'b10;
    slip = 1'b1;
    @(negedge clk);
    slip = 1'b0;
    probe(8, 4'b0000, 1'b1, "R10 slip raises flag");
    mf_edge();
    send_mf(8, 4'b1111);
    mf_edge();
    probe(8, 4'b0000, 1'b1, "R10 second blocked edge");
    mf_edge();
    probe(8, 4'b1111, 1'b0, "R10 capped depth after slip");

    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    if (q.size() > 0) begin
      errors += q.size();
      checks += q.size();
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule